// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles a short conditional branch in one pipeline stage. Each cycle that `in_valid` is high it takes the four arithmetic flags left by the last flag-setting operation, a 4-bit condition selector, the address of the instruction that follows the branch, and a signed 8-bit displacement. One clock later it reports whether the branch goes and which address fetch should use next.

The condition selector has two parts. Bits [3:1] pick one of eight base relations. Bit 0 inverts that relation, so the sixteen codes form eight complementary pairs. Signed orderings come from the exclusive-or of the sign and overflow flags. Unsigned orderings come from the carry flag, which holds the borrow of a compare. A taken branch lands at the next-instruction address plus the sign-extended displacement, wrapping modulo 2^ADDR_W. A branch that is not taken falls through to the next-instruction address unchanged.

Top module: `branch_resolver`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `out_valid`, `out_taken` and `out_pc` are all zero.
- R2: `out_valid` equals the value `in_valid` had one clock earlier.
- R3: Codes 0 and 1: code 0 is taken exactly when OF is 1; code 1 is taken exactly when OF is 0.
- R4: Codes 2 and 3: code 2 (unsigned below) is taken when CF is 1; code 3 (unsigned above-or-equal) is taken when CF is 0.
- R5: Codes 4 and 5: code 4 (equal) is taken when ZF is 1; code 5 (not equal) is taken when ZF is 0.
- R6: Codes 6 and 7: code 6 (unsigned below-or-equal) is taken when CF OR ZF is 1; code 7 (unsigned above) is taken otherwise.
- R7: Codes 8 and 9: code 8 is taken when SF is 1; code 9 is taken when SF is 0.
- R8: Codes 10 and 11: code 10 (signed less) is taken when SF XOR OF is 1; code 11 (signed greater-or-equal) is taken otherwise.
- R9: Codes 12 and 13: code 12 (signed less-or-equal) is taken when ZF OR (SF XOR OF) is 1; code 13 (signed greater) is taken otherwise.
- R10: Code 14 is always taken and code 15 is never taken, whatever the flags.
- R11: For every flag pattern, an odd code gives the opposite decision to the even code just below it.
- R12: When taken, `out_pc` equals `next_pc` plus `disp` sign-extended, modulo 2^ADDR_W. This holds for displacements from -128 to +127, including wrap past zero and past the top of the address space.
- R13: When not taken, `out_pc` equals `next_pc`.
- R14: In a cycle with `in_valid` low, `out_taken` and `out_pc` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A branch is presented this cycle |
| cond_code | input | 4 | Condition selector: [3:1] base relation, [0] invert |
| flag_cf | input | 1 | Carry / borrow flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Signed overflow flag |
| next_pc | input | ADDR_W (32) | Address of the instruction after the branch |
| disp | input | DISP_W (8) | Signed branch displacement in bytes |
| out_valid | output | 1 | Registered result is valid |
| out_taken | output | 1 | Branch decision |
| out_pc | output | ADDR_W (32) | Next fetch address |

## Verification
The result register is the only state, so any internal error shows on the ports in the cycle right after the branch is presented. A base relation that picks the wrong flag combination shows up as a wrong `out_taken` for some of the sixteen flag patterns. An inversion fault gives the same decision on both codes of a pair. A wrong sign extension appears only for negative displacements or at the wrap boundaries, so the stimulus covers every code against every flag pattern and puts both extreme displacements next to address 0 and next to the top of the address range. A register that reloads while `in_valid` is low changes `out_pc` during an idle cycle, which a hold check catches at once.

// File: rtl/brres_pkg.sv
package brres_pkg;

  localparam int COND_W   = 4;
  localparam int NUM_BASE = 2 ** (COND_W - 1);

  // base relation index = cond_code[3:1]; cond_code[0] inverts it
  typedef enum logic [COND_W-2:0] {
    BASE_OVF    = 3'd0,
    BASE_CARRY  = 3'd1,
    BASE_ZERO   = 3'd2,
    BASE_ULE    = 3'd3,
    BASE_SIGN   = 3'd4,
    BASE_SLT    = 3'd5,
    BASE_SLE    = 3'd6,
    BASE_ALWAYS = 3'd7
  } base_sel_t;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  function automatic logic base_relation(base_sel_t sel, flags_t f);
    logic lt_signed;
    lt_signed = f.sf ^ f.of;
    case (sel)
      BASE_OVF:    return f.of;
      BASE_CARRY:  return f.cf;
      BASE_ZERO:   return f.zf;
      BASE_ULE:    return f.cf | f.zf;
      BASE_SIGN:   return f.sf;
      BASE_SLT:    return lt_signed;
      BASE_SLE:    return f.zf | lt_signed;
      default:     return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/brres_cond_eval.sv
module brres_cond_eval
  import brres_pkg::*;
(
  input  flags_t              flags,
  input  logic [COND_W-1:0]   code,
  output logic                base_hit,
  output logic                invert,
  output logic                taken
);

  logic [NUM_BASE-1:0] hit_vec;

  generate
    for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
      assign hit_vec[g] = base_relation(base_sel_t'((COND_W-1)'(g)), flags);
    end
  endgenerate

  assign base_hit = hit_vec[code[COND_W-1:1]];
  assign invert   = code[0];
  assign taken    = base_hit ^ invert;

  // R10: the unconditional pair must not depend on flags
  always_comb begin
    if (code == {COND_W{1'b1}}) begin
      assert_never_R10: assert (taken == 1'b0);
    end
  end

endmodule

// File: rtl/brres_target_gen.sv
module brres_target_gen #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] base_pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] jump_pc
);

  localparam int EXT_W = ADDR_W - DISP_W;

  function automatic logic [ADDR_W-1:0] sext_disp(logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [ADDR_W-1:0] wrap_add(logic [ADDR_W-1:0] a,
                                                 logic [ADDR_W-1:0] b);
    return a + b;
  endfunction

  assign jump_pc = wrap_add(base_pc, sext_disp(disp));

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brres_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        cond_code,
  input  logic              flag_cf,
  input  logic              flag_zf,
  input  logic              flag_sf,
  input  logic              flag_of,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [DISP_W-1:0] disp,
  output logic              out_valid,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_pc
);

  localparam int EXT_W = ADDR_W - DISP_W;

  flags_t            cur_flags;
  logic              base_hit;
  logic              invert;
  logic              taken_c;
  logic [ADDR_W-1:0] jump_pc;
  logic [ADDR_W-1:0] fetch_pc;

  assign cur_flags = '{cf: flag_cf, zf: flag_zf, sf: flag_sf, of: flag_of};

  brres_cond_eval u_eval (
    .flags    (cur_flags),
    .code     (cond_code),
    .base_hit (base_hit),
    .invert   (invert),
    .taken    (taken_c)
  );

  brres_target_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .base_pc (next_pc),
    .disp    (disp),
    .jump_pc (jump_pc)
  );

  assign fetch_pc = taken_c ? jump_pc : next_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_taken <= 1'b0;
      out_pc    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken <= taken_c;
        out_pc    <= fetch_pc;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  assert_idle_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_pc) && $stable(out_taken)));

  assert_fallthrough_R13: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !taken_c |=> out_pc == $past(next_pc));

  assert_jump_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && taken_c |=>
      (out_pc - $past(next_pc)) == {{EXT_W{$past(disp[DISP_W-1])}}, $past(disp)});

  assert_ovf_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cond_code == 4'd0 |=> out_taken == $past(flag_of));

  assert_always_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cond_code == 4'd14 |=> out_taken);

endmodule

// File: tb/sim_branch_resolver.sv
module sim_branch_resolver;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  cond_code = '0;
  logic        flag_cf = 1'b0, flag_zf = 1'b0, flag_sf = 1'b0, flag_of = 1'b0;
  logic [31:0] next_pc = '0;
  logic [7:0]  disp = '0;
  logic        out_valid, out_taken;
  logic [31:0] out_pc;

  int n_checks = 0;
  int n_fail   = 0;

  logic        e_valid = 1'b0, e_taken = 1'b0;
  logic [31:0] e_pc = '0;

  always #2 clk = ~clk;

  branch_resolver u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_code(cond_code),
    .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of),
    .next_pc(next_pc), .disp(disp),
    .out_valid(out_valid), .out_taken(out_taken), .out_pc(out_pc)
  );

  function automatic bit ref_taken(int code, bit cf, bit zf, bit sf, bit of);
    bit less;
    less = (sf != of);
    case (code)
      0:  return of;
      1:  return !of;
      2:  return cf;
      3:  return !cf;
      4:  return zf;
      5:  return !zf;
      6:  return cf || zf;
      7:  return !cf && !zf;
      8:  return sf;
      9:  return !sf;
      10: return less;
      11: return !less;
      12: return zf || less;
      13: return !zf && !less;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string code_tag(int code);
    string t;
    case (code / 2)
      0: t = "R3";  1: t = "R4";  2: t = "R5";  3: t = "R6";
      4: t = "R7";  5: t = "R8";  6: t = "R9";  default: t = "R10";
    endcase
    if (code % 2 == 1) t = {t, "/R11"};
    return t;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, compare at next negedge
  task automatic cyc(bit v, int code, bit cf, bit zf, bit sf, bit of,
                     logic [31:0] pc, logic [7:0] d, string dtag);
    bit tk;
    in_valid = v; cond_code = 4'(code);
    flag_cf = cf; flag_zf = zf; flag_sf = sf; flag_of = of;
    next_pc = pc; disp = d;
    @(posedge clk);
    e_valid = v;
    if (v) begin
      tk = ref_taken(code, cf, zf, sf, of);
      e_taken = tk;
      e_pc = tk ? 32'(longint'(pc) + longint'($signed(d))) : pc;
    end
    @(negedge clk);
    chk("R2 valid", {31'd0, out_valid}, {31'd0, e_valid});
    chk({dtag, " taken"}, {31'd0, out_taken}, {31'd0, e_taken});
    chk(e_taken ? {dtag, "/R12 target"} : {dtag, "/R13 fallthrough"}, out_pc, e_pc);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset taken", {31'd0, out_taken}, 32'd0);
    chk("R1 reset pc", out_pc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset pc", out_pc, 32'd0);

    // every code against every flag pattern
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        cyc(1'b1, c, f[3], f[2], f[1], f[0],
            32'h0000_1000 + 32'(c * 64 + f), 8'(f * 17 - 100), code_tag(c));
      end
    end

    // displacement extremes and wrap (R12)
    cyc(1'b1, 14, 0, 0, 0, 0, 32'h0000_0010, 8'h80, "R12 min wrap low");
    cyc(1'b1, 14, 0, 0, 0, 0, 32'hFFFF_FFF0, 8'h7F, "R12 max wrap high");
    cyc(1'b1, 14, 0, 0, 0, 0, 32'h8000_0000, 8'hFF, "R12 minus one");
    cyc(1'b1, 14, 0, 0, 0, 0, 32'h0000_0000, 8'h00, "R12 zero");
    cyc(1'b1, 15, 1, 1, 1, 1, 32'hFFFF_FFFF, 8'h80, "R13 never");

    // idle cycles with noisy inputs: outputs hold (R14)
    cyc(1'b1, 4, 0, 1, 0, 0, 32'h1234_5678, 8'h20, "R5 pre-idle");
    for (int k = 0; k < 6; k++) begin
      cyc(1'b0, k, 1, 1, 0, 1, 32'hDEAD_0000 + 32'(k), 8'(k * 40), "R14 idle");
    end
    cyc(1'b1, 5, 0, 1, 0, 0, 32'h0000_4000, 8'h10, "R5/R11 after idle");
    cyc(1'b0, 14, 0, 0, 0, 0, 32'hAAAA_AAAA, 8'h7F, "R14 idle");

    finish_run();
  end

endmodule